// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus with 16-bit data. Software sets a 15-bit timeout in units of one tick and then keeps the timer alive by writing a fixed key word to a service register. Each tick is nominally 10 ms, and its length is set by a cycle-count parameter. If software stops servicing the timer, the count reaches its end. At that point the block pulses a reset request for a set number of cycles and records a sticky expiry code. It then reloads and keeps counting.

Every action that changes the timer's state needs its own 16-bit key. Stopping the timer needs two writes to two registers in a fixed order. A stopped timer must be re-armed with a resume key before a service write starts it again. One tick before expiry the block raises an early-warning event. Software can mask that event, clear it, or force it. A debug-hold register decides whether the count advances while a debugger is attached.

Reads are combinational from the current state. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `keyed_wdog`

## Requirements
- R1: The register word indices are: service 0, timeout 1, stop-key-A 2, stop-key-B 3, status 4, count 5, debug-hold 6, resume 7, event 8, mask 9, force 10. After reset the timer is idle and not stopped: stop-key-B reads 0x0000, status reads 0x0000, count reads 0x0000, timeout reads the TMO_INIT parameter (default 0x7FFF), debug-hold bit 0 and event bit 0 read 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0xFEED to the service register, while the timer is not stopped, loads the count from the timeout register and restarts the tick prescaler. Count register bits [14:0] show the remaining count, which drops by one every TICK_DIV cycles while the timer runs.
- R3: A write of any other value to the service register has no effect.
- R4: The timeout register keeps only bits [14:0] of a write and reads 0 in bit 15.
- R5: When the count reaches its end, the block does three things at the same edge. It asserts `rst_req_o` for exactly RST_CYC cycles, it reloads the count from the timeout register, and it keeps running. The first expiry comes timeout×TICK_DIV cycles after a service write.
- R6: After an expiry the status register reads 0xCFE8. Only a write of 0xE8B4 returns it to 0x0000; other values are ignored.
- R7: Writing 0x2BAD to stop-key-A, then 0xCAFE to stop-key-B, stops the timer. A stopped timer reads 0xDABE from stop-key-B, and 0x0000 while not stopped. While stopped the count holds and no reset request is issued. A stop-key-B write without a valid preceding stop-key-A key is ignored. Any other stop-key-A value clears the arming, and so does any stop-key-B write.
- R8: While stopped, service writes are ignored. Writing 0xACED to the resume register re-arms the timer, which reads 0x0000 from stop-key-B and holds its count until the next 0xFEED service write starts it. Other resume values are ignored.
- R9: Count register bit 15 is 1 in exactly the cycles in which the count is being updated (tick or load), and 0 otherwise.
- R10: Event bit 0 is set at the tick that leaves one tick remaining, which is TICK_DIV cycles before expiry. `irq_o` is high only while event bit 0 and mask bit 0 are both 1. Writing 1 to event bit 0 clears it.
- R11: While force register bit 0 is 1, event bit 0 is set every cycle and cannot be cleared.
- R12: Debug-hold bit 1 reads the `dbg_attached` input. While `dbg_attached` is high and debug-hold bit 0 is 0, the count holds. Setting bit 0 lets it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register word index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at `addr` (combinational) |
| dbg_attached | input | 1 | A debugger is attached |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request pulse on expiry |

## Verification
If the stop-key arming flag were wrong, the timer would either refuse to stop or stop on a single write. Either fault shows in the next stop-key-B read, one cycle after the key writes. A prescaler or count that is off by one moves the warning and the reset pulse by whole ticks. The bench therefore measures the cycle distances from the service write to `irq_o` and from `irq_o` to `rst_req_o`, and checks the pulse width. A stuck hold condition, whether from the stop state or from the debugger, shows as a count read that has not changed after more than one tick period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W = 15;

  localparam logic [3:0] A_SERVICE = 4'd0;
  localparam logic [3:0] A_TMO     = 4'd1;
  localparam logic [3:0] A_STOPA   = 4'd2;
  localparam logic [3:0] A_STOPB   = 4'd3;
  localparam logic [3:0] A_STAT    = 4'd4;
  localparam logic [3:0] A_CNT     = 4'd5;
  localparam logic [3:0] A_DBG     = 4'd6;
  localparam logic [3:0] A_RESUME  = 4'd7;
  localparam logic [3:0] A_EVT     = 4'd8;
  localparam logic [3:0] A_MSK     = 4'd9;
  localparam logic [3:0] A_FRC     = 4'd10;

  localparam logic [15:0] KEY_SERVICE = 16'hFEED;
  localparam logic [15:0] KEY_STOPA   = 16'h2BAD;
  localparam logic [15:0] KEY_STOPB   = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME  = 16'hACED;
  localparam logic [15:0] KEY_CLEAR   = 16'hE8B4;
  localparam logic [15:0] CODE_STOP   = 16'hDABE;
  localparam logic [15:0] CODE_EXP    = 16'hCFE8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_STOP} wd_state_e;

  // status-style readback: a fixed code when the flag is set, else zero
  function automatic logic [15:0] code_if(input logic flag, input logic [15:0] code);
    return flag ? code : 16'h0000;
  endfunction

  // true when the coming tick ends the countdown
  function automatic logic final_step(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  // true when the coming tick leaves exactly one tick remaining
  function automatic logic warn_step(input logic [CNT_W-1:0] c);
    return c == CNT_W'(2);
  endfunction
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned TICK_DIV = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (run)  pre_q <= tick ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_service,
  input  logic             wr_stopa,
  input  logic             wr_stopb,
  input  logic             wr_stat,
  input  logic             wr_resume,
  input  logic [15:0]      wdata,
  input  logic             expire,
  output wd_state_e        st,
  output logic             feed_ok,
  output logic             timed_out
);
  wd_state_e st_q;
  logic      arm_q;
  logic      stop_ok;
  logic      resume_ok;
  logic      clear_ok;

  assign feed_ok   = wr_service && (wdata == KEY_SERVICE) && (st_q != ST_STOP);
  assign stop_ok   = wr_stopb && (wdata == KEY_STOPB) && arm_q;
  assign resume_ok = wr_resume && (wdata == KEY_RESUME) && (st_q == ST_STOP);
  assign clear_ok  = wr_stat && (wdata == KEY_CLEAR);
  assign st        = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      arm_q     <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      if (wr_stopa)      arm_q <= (wdata == KEY_STOPA);
      else if (wr_stopb) arm_q <= 1'b0;

      if (stop_ok)        st_q <= ST_STOP;
      else if (resume_ok) st_q <= ST_IDLE;
      else if (feed_ok)   st_q <= ST_RUN;

      if (expire)        timed_out <= 1'b1;
      else if (clear_ok) timed_out <= 1'b0;
    end
  end

  AST_STOP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_STOP) |-> $past(arm_q));  // R7
  AST_STATUS_CLEAR_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timed_out) |-> $past(wr_stat && wdata == KEY_CLEAR));  // R6
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] tmo,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             warn,
  output logic             expire,
  output logic             rst_req
);
  localparam int unsigned RW = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    pulse_q;

  assign expire  = tick && final_step(cnt_q);
  assign warn    = tick && warn_step(cnt_q);
  assign busy    = load || tick;
  assign cnt     = cnt_q;
  assign rst_req = (pulse_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else begin
      if (load || expire) cnt_q <= tmo;
      else if (tick)      cnt_q <= cnt_q - 1'b1;

      if (expire)             pulse_q <= RW'(RST_CYC);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end
  end

  AST_PULSE_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_req);  // R5
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_DIV = 500000,
  parameter int unsigned RST_CYC  = 16,
  parameter logic [14:0] TMO_INIT = 15'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        dbg_attached,
  output logic        irq_o,
  output logic        rst_req_o
);
  // register write strobes, one per register
  logic wr_service, wr_tmo, wr_stopa, wr_stopb, wr_stat;
  logic wr_dbg, wr_resume, wr_evt, wr_msk, wr_frc;

  assign wr_service = wr_en && (addr == A_SERVICE);
  assign wr_tmo     = wr_en && (addr == A_TMO);
  assign wr_stopa   = wr_en && (addr == A_STOPA);
  assign wr_stopb   = wr_en && (addr == A_STOPB);
  assign wr_stat    = wr_en && (addr == A_STAT);
  assign wr_dbg     = wr_en && (addr == A_DBG);
  assign wr_resume  = wr_en && (addr == A_RESUME);
  assign wr_evt     = wr_en && (addr == A_EVT);
  assign wr_msk     = wr_en && (addr == A_MSK);
  assign wr_frc     = wr_en && (addr == A_FRC);

  logic [CNT_W-1:0] tmo_q;
  logic             msk_q, frc_q, evt_q, dbg_run_q;

  // internal events, named for the assertions
  wd_state_e        st;
  logic             feed_ok, timed_out, run, tick;
  logic             warn, expire, busy;
  logic [CNT_W-1:0] cnt;

  assign run = (st == ST_RUN) && (!dbg_attached || dbg_run_q);

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_service(wr_service), .wr_stopa(wr_stopa), .wr_stopb(wr_stopb),
    .wr_stat(wr_stat), .wr_resume(wr_resume), .wdata(wdata),
    .expire(expire), .st(st), .feed_ok(feed_ok), .timed_out(timed_out)
  );

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(feed_ok), .tick(tick)
  );

  wdog_count #(.RST_CYC(RST_CYC)) u_count (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .tmo(tmo_q), .tick(tick),
    .cnt(cnt), .busy(busy), .warn(warn), .expire(expire), .rst_req(rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q     <= TMO_INIT;
      msk_q     <= 1'b0;
      frc_q     <= 1'b0;
      evt_q     <= 1'b0;
      dbg_run_q <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q     <= wdata[CNT_W-1:0];
      if (wr_msk) msk_q     <= wdata[0];
      if (wr_frc) frc_q     <= wdata[0];
      if (wr_dbg) dbg_run_q <= wdata[0];
      if (warn || frc_q)          evt_q <= 1'b1;
      else if (wr_evt && wdata[0]) evt_q <= 1'b0;
    end
  end

  assign irq_o = evt_q && msk_q;

  always_comb begin
    case (addr)
      A_TMO:   rdata = {1'b0, tmo_q};
      A_STOPB: rdata = code_if(st == ST_STOP, CODE_STOP);
      A_STAT:  rdata = code_if(timed_out, CODE_EXP);
      A_CNT:   rdata = {busy, cnt};
      A_DBG:   rdata = {14'd0, dbg_attached, dbg_run_q};
      A_EVT:   rdata = {15'd0, evt_q};
      A_MSK:   rdata = {15'd0, msk_q};
      A_FRC:   rdata = {15'd0, frc_q};
      default: rdata = 16'h0000;
    endcase
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> msk_q);  // R10
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_STOP) |-> $stable(cnt));  // R7
  AST_HOLD_UNDER_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_attached && !dbg_run_q && !feed_ok) |-> $stable(cnt));  // R12
  AST_FORCE_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    frc_q |=> evt_q);  // R11
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  localparam int unsigned TDIV = 8;
  localparam int unsigned RCYC = 3;
  localparam int unsigned TMO  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        dbg = 1'b0;
  logic        irq, rstq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  keyed_wdog #(.TICK_DIV(TDIV), .RST_CYC(RCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_attached(dbg), .irq_o(irq), .rst_req_o(rstq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd3, d);  check("R1 stop-key-B", d, 16'h0000);
    rd(4'd4, d);  check("R1 status", d, 16'h0000);
    rd(4'd5, d);  check("R1 count", d, 16'h0000);
    rd(4'd1, d);  check("R1 timeout", d, 16'h7FFF);
    rd(4'd6, d);  check("R1 debug-hold", d, 16'h0000);
    rd(4'd8, d);  check("R1 event", d, 16'h0000);
    check("R1 irq/rst", {14'd0, irq, rstq}, 16'h0000);
  endtask

  task automatic t_timeout_reg();
    logic [15:0] d;
    wr(4'd1, 16'hFFFF); rd(4'd1, d); check("R4 bit15 dropped", d, 16'h7FFF);
    wr(4'd1, 16'(TMO)); rd(4'd1, d); check("R4 timeout value", d, 16'(TMO));
  endtask

  task automatic t_bad_service();
    logic [15:0] d;
    wr(4'd0, 16'h1234);
    cyc(3 * TDIV);
    rd(4'd5, d); check("R3 wrong service key ignored", d, 16'h0000);
  endtask

  task automatic t_run_expire();
    logic [15:0] d;
    int n, m, w;
    wr(4'd9, 16'h0001);
    wr(4'd0, 16'hFEED);
    rd(4'd5, d); check("R2 count loaded", d, 16'(TMO));
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    check("R10 warning one tick early", 16'(n), 16'((TMO - 1) * TDIV));
    m = 0;
    while (!rstq && m < 1000) begin @(negedge clk); m++; end
    check("R5 expiry after full timeout", 16'(n + m), 16'(TMO * TDIV));
    check("R10 warning to expiry", 16'(m), 16'(TDIV));
    w = 0;
    while (rstq && w < 1000) begin @(negedge clk); w++; end
    check("R5 reset pulse width", 16'(w), 16'(RCYC));
    rd(4'd5, d); check("R5 reloaded", d, 16'(TMO));
    rd(4'd4, d); check("R6 expired code", d, 16'hCFE8);
    wr(4'd8, 16'h0001); rd(4'd8, d); check("R10 event cleared", d, 16'h0000);
    check("R10 irq low after clear", {15'd0, irq}, 16'h0000);
    wr(4'd4, 16'h1111); rd(4'd4, d); check("R6 wrong clear key ignored", d, 16'hCFE8);
    wr(4'd4, 16'hE8B4); rd(4'd4, d); check("R6 status cleared", d, 16'h0000);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    logic [14:0] v;
    int k;
    wr(4'd0, 16'hFEED);
    k = 0;
    rd(4'd5, d);
    while (!d[15] && k < 4 * TDIV) begin @(negedge clk); rd(4'd5, d); k++; end
    check("R9 busy seen on tick", {15'd0, d[15]}, 16'h0001);
    v = d[14:0];
    @(negedge clk); rd(4'd5, d);
    check("R9 busy cleared after update", {15'd0, d[15]}, 16'h0000);
    check("R2 one step per tick", {1'b0, d[14:0]}, (v > 1) ? 16'(v - 1) : 16'(TMO));
  endtask

  task automatic t_stop_bad();
    logic [15:0] d;
    wr(4'd0, 16'hFEED);
    wr(4'd3, 16'hCAFE); rd(4'd3, d); check("R7 stop-key-B alone ignored", d, 16'h0000);
    wr(4'd2, 16'h2BAD); wr(4'd2, 16'h0000);
    wr(4'd3, 16'hCAFE); rd(4'd3, d); check("R7 arming cleared by bad key", d, 16'h0000);
  endtask

  task automatic t_stop_resume();
    logic [15:0] d, v;
    bit saw_rst;
    wr(4'd2, 16'h2BAD); wr(4'd3, 16'hCAFE);
    rd(4'd3, d); check("R7 stopped code", d, 16'hDABE);
    rd(4'd5, v);
    saw_rst = 0;
    for (int i = 0; i < 6 * TDIV; i++) begin @(negedge clk); if (rstq) saw_rst = 1; end
    rd(4'd5, d); check("R7 count holds when stopped", d, v);
    check("R7 no reset when stopped", {15'd0, saw_rst}, 16'h0000);
    wr(4'd0, 16'hFEED); rd(4'd3, d); check("R8 service ignored when stopped", d, 16'hDABE);
    rd(4'd5, d); check("R8 count unchanged by service", d, v);
    wr(4'd7, 16'h0001); rd(4'd3, d); check("R8 wrong resume ignored", d, 16'hDABE);
    wr(4'd7, 16'hACED); rd(4'd3, d); check("R8 resumed", d, 16'h0000);
    cyc(2 * TDIV);
    rd(4'd5, d); check("R8 idle holds until service", d, v);
    wr(4'd0, 16'hFEED); rd(4'd5, d); check("R8 service starts", d, 16'(TMO));
    cyc(TDIV + 1);
    rd(4'd5, d); check("R8 counting again", d, 16'(TMO - 1));
  endtask

  task automatic t_debug();
    logic [15:0] d, v;
    dbg = 1'b1;
    cyc(2);
    rd(4'd6, d); check("R12 debug indication", d, 16'h0002);
    rd(4'd5, v);
    cyc(4 * TDIV);
    rd(4'd5, d); check("R12 count holds under debugger", d, v);
    wr(4'd6, 16'h0001); rd(4'd6, d); check("R12 run-under-debug set", d, 16'h0003);
    rd(4'd5, v);
    cyc(TDIV + 1);
    rd(4'd5, d);
    n_chk++;
    if (d[14:0] == v[14:0]) begin
      n_fail++;
      $display("FAIL R12 count should move: actual 0x%04h expected not 0x%04h", d, v);
    end
    dbg = 1'b0;
    wr(4'd6, 16'h0000);
  endtask

  task automatic t_force();
    logic [15:0] d;
    wr(4'd2, 16'h2BAD); wr(4'd3, 16'hCAFE);
    wr(4'd8, 16'h0001);
    check("R10 irq low before force", {15'd0, irq}, 16'h0000);
    wr(4'd10, 16'h0001); cyc(1);
    check("R11 force raises irq", {15'd0, irq}, 16'h0001);
    wr(4'd8, 16'h0001); cyc(1);
    rd(4'd8, d); check("R11 clear blocked while forced", d, 16'h0001);
    wr(4'd10, 16'h0000); wr(4'd8, 16'h0001);
    rd(4'd8, d); check("R10 event cleared after force off", d, 16'h0000);
    wr(4'd9, 16'h0000); wr(4'd10, 16'h0001); cyc(1);
    rd(4'd8, d); check("R11 event set while masked", d, 16'h0001);
    check("R10 mask blocks irq", {15'd0, irq}, 16'h0000);
    wr(4'd10, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_timeout_reg();
    t_bad_service();
    t_run_expire();
    t_busy();
    t_stop_bad();
    t_stop_resume();
    t_debug();
    t_force();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule